// File: doc/BRIEF.md
# Target Bus Phase Sequencer

This block sequences the information-transfer phases of a peripheral target on a parallel peripheral bus. While idle it watches the sampled bus lines for its own selection. Selection needs SEL and the data line given by its own ID both true, with BSY and I/O false, held for a programmable settle time. It then takes BSY and walks the phases in a fixed order: command, optional data, one status byte, one message byte, and bus release. In each phase it drives the C/D, I/O and MSG lines with that phase's encoding.

Byte transfers are carried out by a separate handshake engine. The sequencer raises a request level while bytes remain in the current phase. The engine reports each finished byte with a done pulse and, for command bytes, the received value. The sequencer reads the number of command bytes from the group code of the opcode. It takes the data length and direction from local inputs and supplies the status and message bytes. Phase lines are only changed while the bus REQ line is low. A bus reset drops every line at once.

Top module: `tgt_phase_seq`

## Requirements
- R1: BSY is asserted only after SEL, the data line at index own_id_i, not-BSY and not-I/O have all held true for SETTLE_CYC consecutive clocks while idle. bsy_o rises on the clock edge after the SETTLE_CYC-th such clock. A shorter hold, or a wrong ID line, leaves bsy_o low.
- R2: The first phase after selection is command, with {cd,io,msg} = 3'b100. The number of command bytes is set by opcode bits [7:5]: group 0 gives 6 bytes, groups 1 and 2 give 10 bytes, and group 5 gives 12 bytes.
- R3: An opcode whose group is 3, 4, 6 or 7 ends the command phase after that single byte. The data phase is skipped, and the status byte is 8'h02 whatever status_i holds.
- R4: When data_len_i is non-zero at the end of the command phase, a data phase of exactly data_len_i bytes follows. It is data-in ({cd,io,msg} = 3'b010) when data_in_i = 1 and data-out (3'b000) when data_in_i = 0.
- R5: When data_len_i is zero at the end of the command phase, the status phase follows the command phase directly.
- R6: The status phase has {cd,io,msg} = 3'b110 and transfers exactly one byte, with tx_byte_o equal to status_i (or 8'h02 under R3).
- R7: The message phase has {cd,io,msg} = 3'b111 and transfers exactly one byte, with tx_byte_o = 8'h00. Once that byte is done, bsy_o and all phase lines drop and the block returns to idle.
- R8: After a phase's last byte, the phase lines keep their value for as long as req_line_i is high. The next phase starts on the first clock edge at which req_line_i is low.
- R9: While bus_rst_i is high, bsy_o, cd_o, io_o, msg_o and hs_req_o are low in the same cycle. Once it drops, the block is idle and can be selected again.
- R10: hs_req_o is high only while the current phase has bytes outstanding. byte_cnt_o gives the number of bytes done in the current phase. byte_stb_o pulses with each accepted hs_done_i, and hs_done_i has no effect when no request is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_rst_i | input | 1 | Sampled bus reset line |
| sel_i | input | 1 | Sampled SEL line |
| bsy_i | input | 1 | Sampled BSY line from other devices |
| io_i | input | 1 | Sampled I/O line |
| data_i | input | 8 | Sampled data lines |
| own_id_i | input | 3 | Own device ID (index of its data line) |
| data_len_i | input | CNT_W | Number of data bytes for this command |
| data_in_i | input | 1 | 1 = data-in (target to initiator), 0 = data-out |
| status_i | input | 8 | Status byte to return |
| req_line_i | input | 1 | Current level of the bus REQ line |
| hs_done_i | input | 1 | Handshake engine finished one byte |
| hs_rx_i | input | 8 | Byte received by the handshake engine |
| bsy_o | output | 1 | BSY drive |
| cd_o | output | 1 | C/D drive |
| io_o | output | 1 | I/O drive |
| msg_o | output | 1 | MSG drive |
| hs_req_o | output | 1 | Request for a byte transfer in the current phase |
| tx_byte_o | output | 8 | Status or message byte to send |
| byte_cnt_o | output | CNT_W | Bytes done in the current phase |
| byte_stb_o | output | 1 | Pulse per accepted byte |

## Verification
A wrong phase register shows on the very next clock as a wrong C/D, I/O, MSG combination while hs_req_o is high. A wrong byte count or a wrong length decode shows when the phase ends: the request either drops one or more bytes early, or stays high after the expected last byte. A stuck BSY or an ignored REQ level shows within a few cycles of the message byte, or of the command phase that is held open, as lines that fail to fall or that change too early. A lost bus reset shows at once as lines still driven during reset.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int BYTE_W = 8;
  localparam int ID_W   = $clog2(BYTE_W);

  localparam logic [BYTE_W-1:0] ST_CHECK = 8'h02;
  localparam logic [BYTE_W-1:0] MSG_DONE = 8'h00;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_DIN, PH_DOUT, PH_STAT, PH_MSG
  } phase_e;

  // command length from group code, 0 = unsupported group
  function automatic logic [3:0] cmd_len(input logic [2:0] grp);
    case (grp)
      3'd0:       return 4'd6;
      3'd1, 3'd2: return 4'd10;
      3'd5:       return 4'd12;
      default:    return 4'd0;
    endcase
  endfunction

  // {cd, io, msg}
  function automatic logic [2:0] phase_lines(input phase_e ph);
    case (ph)
      PH_CMD:  return 3'b100;
      PH_DIN:  return 3'b010;
      PH_DOUT: return 3'b000;
      PH_STAT: return 3'b110;
      PH_MSG:  return 3'b111;
      default: return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/tps_sel_detect.sv
module tps_sel_detect #(
  parameter int SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic arm_i,
  input  logic sel_i,
  input  logic bsy_i,
  input  logic io_i,
  input  logic id_bit_i,
  output logic hit_o
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic          cond;
  logic [CW-1:0] cnt_q;

  assign cond  = arm_i & sel_i & id_bit_i & ~bsy_i & ~io_i;
  assign hit_o = cond & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || !cond)  cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tps_byte_ctr.sv
module tps_byte_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tps_phase_fsm.sv
module tps_phase_fsm
  import tps_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              sel_hit_i,
  input  logic              req_line_i,
  input  logic              hs_done_i,
  input  logic [BYTE_W-1:0] hs_rx_i,
  input  logic [CNT_W-1:0]  data_len_i,
  input  logic              data_in_i,
  input  logic [BYTE_W-1:0] status_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output phase_e            phase_o,
  output logic              bsy_o,
  output logic              hs_req_o,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  output logic [BYTE_W-1:0] tx_byte_o
);
  phase_e             state_q, next_ph;
  logic               bsy_q, done_q, bad_q;
  logic [3:0]         need_q;
  logic [CNT_W-1:0]   len_q;
  logic [3:0]         first_need;
  logic               xfer, last, advance;
  logic [CNT_W-1:0]   cnt_nxt;

  assign first_need = cmd_len(hs_rx_i[BYTE_W-1 -: 3]);
  assign hs_req_o   = (state_q != PH_IDLE) & ~done_q & ~bus_rst_i;
  assign xfer       = hs_req_o & hs_done_i;
  assign advance    = (state_q != PH_IDLE) & done_q & ~req_line_i;
  assign cnt_nxt    = cnt_i + 1'b1;
  assign cnt_inc_o  = xfer;
  assign cnt_clr_o  = advance | bus_rst_i | (state_q == PH_IDLE);
  assign phase_o    = state_q;
  assign bsy_o      = bsy_q;

  always_comb begin
    case (state_q)
      PH_CMD:           last = (cnt_i == '0) ? (first_need == 4'd0)
                                             : (cnt_nxt == CNT_W'(need_q));
      PH_DIN, PH_DOUT:  last = (cnt_nxt == len_q);
      PH_STAT, PH_MSG:  last = 1'b1;
      default:          last = 1'b0;
    endcase
  end

  always_comb begin
    case (state_q)
      PH_CMD: begin
        if (bad_q || data_len_i == '0) next_ph = PH_STAT;
        else if (data_in_i)            next_ph = PH_DIN;
        else                           next_ph = PH_DOUT;
      end
      PH_DIN, PH_DOUT: next_ph = PH_STAT;
      PH_STAT:         next_ph = PH_MSG;
      default:         next_ph = PH_IDLE;
    endcase
  end

  always_comb begin
    if (state_q == PH_STAT) tx_byte_o = bad_q ? ST_CHECK : status_i;
    else                    tx_byte_o = MSG_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      bsy_q   <= 1'b0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
      need_q  <= '0;
      len_q   <= '0;
    end else if (bus_rst_i) begin
      state_q <= PH_IDLE;
      bsy_q   <= 1'b0;
      done_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else if (state_q == PH_IDLE) begin
      if (sel_hit_i) begin
        state_q <= PH_CMD;
        bsy_q   <= 1'b1;
        done_q  <= 1'b0;
        bad_q   <= 1'b0;
      end
    end else begin
      if (xfer) begin
        if (state_q == PH_CMD && cnt_i == '0) begin
          need_q <= first_need;
          bad_q  <= (first_need == 4'd0);
        end
        if (last) done_q <= 1'b1;
      end
      if (advance) begin
        state_q <= next_ph;
        done_q  <= 1'b0;
        if (state_q == PH_CMD) len_q <= data_len_i;
        if (state_q == PH_MSG) bsy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tgt_phase_seq.sv
module tgt_phase_seq
  import tps_pkg::*;
#(
  parameter int SETTLE_CYC = 4,
  parameter int CNT_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_rst_i,
  input  logic              sel_i,
  input  logic              bsy_i,
  input  logic              io_i,
  input  logic [7:0]        data_i,
  input  logic [2:0]        own_id_i,
  input  logic [CNT_W-1:0]  data_len_i,
  input  logic              data_in_i,
  input  logic [7:0]        status_i,
  input  logic              req_line_i,
  input  logic              hs_done_i,
  input  logic [7:0]        hs_rx_i,
  output logic              bsy_o,
  output logic              cd_o,
  output logic              io_o,
  output logic              msg_o,
  output logic              hs_req_o,
  output logic [7:0]        tx_byte_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              byte_stb_o
);
  phase_e     phase;
  logic       sel_hit, bsy_int, cnt_clr, cnt_inc;
  logic [2:0] lines;

  tps_sel_detect #(.SETTLE_CYC(SETTLE_CYC)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (bus_rst_i),
    .arm_i    (phase == PH_IDLE),
    .sel_i    (sel_i),
    .bsy_i    (bsy_i),
    .io_i     (io_i),
    .id_bit_i (data_i[own_id_i]),
    .hit_o    (sel_hit)
  );

  tps_byte_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .cnt_o  (byte_cnt_o)
  );

  tps_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bus_rst_i  (bus_rst_i),
    .sel_hit_i  (sel_hit),
    .req_line_i (req_line_i),
    .hs_done_i  (hs_done_i),
    .hs_rx_i    (hs_rx_i),
    .data_len_i (data_len_i),
    .data_in_i  (data_in_i),
    .status_i   (status_i),
    .cnt_i      (byte_cnt_o),
    .phase_o    (phase),
    .bsy_o      (bsy_int),
    .hs_req_o   (hs_req_o),
    .cnt_clr_o  (cnt_clr),
    .cnt_inc_o  (cnt_inc),
    .tx_byte_o  (tx_byte_o)
  );

  // bus reset releases lines combinationally
  assign lines      = phase_lines(phase) & ~{3{bus_rst_i}};
  assign cd_o       = lines[2];
  assign io_o       = lines[1];
  assign msg_o      = lines[0];
  assign bsy_o      = bsy_int & ~bus_rst_i;
  assign byte_stb_o = cnt_inc;
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int CNT_W = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_rst_i,
  input logic       sel_i,
  input logic       bsy_i,
  input logic       io_i,
  input logic [7:0] data_i,
  input logic [2:0] own_id_i,
  input logic       req_line_i,
  input logic       bsy_o,
  input logic       cd_o,
  input logic       io_o,
  input logic       msg_o,
  input logic       hs_req_o,
  input logic [7:0] tx_byte_o
);
  a_r1_bsy_after_select: assert property (@(posedge clk_i) disable iff (!rst_ni || bus_rst_i)
    $rose(bsy_o) |-> $past(sel_i && data_i[own_id_i] && !bsy_i && !io_i));

  a_r7_msg_encoding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_o |-> (cd_o && io_o));

  a_r7_msg_byte_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_o && hs_req_o) |-> (tx_byte_o == 8'h00));

  a_r7_bsy_drop_after_msg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bsy_o) && !bus_rst_i) |-> $past(msg_o));

  a_r8_lines_hold_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni || bus_rst_i)
    (req_line_i && bsy_o) |=> $stable({cd_o, io_o, msg_o}));

  a_r9_bus_reset_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |-> !(bsy_o || cd_o || io_o || msg_o || hs_req_o));

  a_r10_req_needs_bsy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_req_o |-> bsy_o);
endmodule

bind tgt_phase_seq tps_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tgt_phase_seq_tb_top.sv
`timescale 1ns/1ps
module tgt_phase_seq_tb_top;
  localparam int S = 4;
  localparam int CW = 16;
  localparam logic [2:0] OWN = 3'd5;

  typedef struct packed {
    logic [7:0]  op;
    logic [15:0] len;
    logic        din;
    logic [7:0]  st;
    logic [3:0]  ncmd;
    logic [7:0]  est;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{8'h08, 16'd3, 1'b1, 8'h00, 4'd6,  8'h00},
    '{8'h2A, 16'd2, 1'b0, 8'h00, 4'd10, 8'h00},
    '{8'h5A, 16'd0, 1'b1, 8'h18, 4'd10, 8'h18},
    '{8'hA8, 16'd1, 1'b1, 8'h00, 4'd12, 8'h00},
    '{8'h60, 16'd2, 1'b1, 8'h00, 4'd1,  8'h02},
    '{8'hE0, 16'd5, 1'b0, 8'h00, 4'd1,  8'h02},
    '{8'h00, 16'd0, 1'b0, 8'h08, 4'd6,  8'h08}
  };

  logic clk = 0, rst_n = 0;
  logic bus_rst = 0, sel = 0, bsy_in = 0, io_in = 0;
  logic [7:0] data = 0, status = 0, rx = 0;
  logic [CW-1:0] dlen = 0;
  logic din = 0, req_line = 0, hs_done = 0;
  logic bsy, cd, io, msg, hs_req, stb;
  logic [7:0] tx;
  logic [CW-1:0] bcnt;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tgt_phase_seq #(.SETTLE_CYC(S), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_i(bus_rst), .sel_i(sel), .bsy_i(bsy_in),
    .io_i(io_in), .data_i(data), .own_id_i(OWN), .data_len_i(dlen), .data_in_i(din),
    .status_i(status), .req_line_i(req_line), .hs_done_i(hs_done), .hs_rx_i(rx),
    .bsy_o(bsy), .cd_o(cd), .io_o(io), .msg_o(msg), .hs_req_o(hs_req),
    .tx_byte_o(tx), .byte_cnt_o(bcnt), .byte_stb_o(stb)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic select_me(input string tag);
    @(negedge clk);
    sel = 1; data = 8'h01 << OWN;
    repeat (S) @(posedge clk);
    @(negedge clk);
    chk(bsy === 1'b1, tag, bsy, 1);
    sel = 0; data = 0;
  endtask

  task automatic xfer_byte(input logic [7:0] b);
    hs_done = 1; rx = b;
    #1 chk(stb === 1'b1, "R10 strobe", stb, 1);
    @(negedge clk);
    hs_done = 0;
  endtask

  task automatic run_phase(input logic [2:0] exp_l, input int n, input logic [7:0] first,
                           input string tag, input bit chk_tx, input logic [7:0] exp_tx);
    for (int w = 0; w < 20 && !hs_req; w++) @(negedge clk);
    chk({cd, io, msg} === exp_l, tag, {cd, io, msg}, exp_l);
    for (int k = 0; k < n; k++) begin
      chk(hs_req === 1'b1 && bcnt == CW'(k), {tag, " count"}, bcnt, k);
      if (chk_tx) chk(tx === exp_tx, {tag, " tx"}, tx, exp_tx);
      xfer_byte(k == 0 ? first : 8'h11);
    end
    chk(hs_req === 1'b0, {tag, " end"}, hs_req, 0);
  endtask

  task automatic run_vec(input vec_t v);
    dlen = v.len; din = v.din; status = v.st;
    select_me("R1 select");
    run_phase(3'b100, int'(v.ncmd), v.op, v.ncmd == 1 ? "R3 cmd" : "R2 cmd", 0, 0);
    if (v.ncmd != 1 && v.len != 0)
      run_phase(v.din ? 3'b010 : 3'b000, int'(v.len), 8'h00, "R4 data", 0, 0);
    run_phase(3'b110, 1, 8'h00,
              v.ncmd == 1 ? "R3 status" : (v.len == 0 ? "R5 status" : "R6 status"), 1, v.est);
    run_phase(3'b111, 1, 8'h00, "R7 msg", 1, 8'h00);
    @(negedge clk);
    chk(bsy === 1'b0 && {cd, io, msg} === 3'b000, "R7 release", {bsy, cd, io, msg}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bsy === 0 && hs_req === 0 && {cd, io, msg} === 0, "R10 reset", {bsy, hs_req, cd, io, msg}, 0);
    rst_n = 1;
    @(negedge clk);
    // done with no open request is ignored
    hs_done = 1; #1 chk(stb === 1'b0, "R10 idle strobe", stb, 0);
    @(negedge clk); hs_done = 0;
    chk(bcnt == 0 && hs_req === 0, "R10 idle count", bcnt, 0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R1 settle one short
    sel = 1; data = 8'h01 << OWN;
    repeat (S - 1) @(posedge clk);
    @(negedge clk); sel = 0; data = 0;
    repeat (3) @(negedge clk);
    chk(bsy === 1'b0, "R1 short settle", bsy, 0);
    // R1 wrong ID line
    sel = 1; data = 8'h01 << (OWN - 1);
    repeat (S + 3) @(negedge clk);
    chk(bsy === 1'b0, "R1 wrong id", bsy, 0);
    // R1 BSY held by another device
    data = 8'h01 << OWN; bsy_in = 1;
    repeat (S + 3) @(negedge clk);
    chk(bsy === 1'b0, "R1 busy bus", bsy, 0);
    sel = 0; data = 0; bsy_in = 0;

    // R8 REQ held high at end of command phase
    dlen = 0; status = 8'h00;
    select_me("R1 select");
    req_line = 1;
    run_phase(3'b100, 6, 8'h00, "R2 cmd", 0, 0);
    repeat (5) @(negedge clk);
    chk({cd, io, msg} === 3'b100 && hs_req === 0, "R8 hold", {cd, io, msg}, 3'b100);
    req_line = 0;
    run_phase(3'b110, 1, 8'h00, "R8 next", 1, 8'h00);
    run_phase(3'b111, 1, 8'h00, "R7 msg", 1, 8'h00);
    @(negedge clk);
    chk(bsy === 1'b0, "R7 release", bsy, 0);

    // R9 bus reset in data phase
    dlen = 3; din = 1;
    select_me("R1 select");
    run_phase(3'b100, 6, 8'h08, "R2 cmd", 0, 0);
    for (int w = 0; w < 20 && !hs_req; w++) @(negedge clk);
    xfer_byte(8'h11);
    bus_rst = 1;
    #1 chk({bsy, cd, io, msg, hs_req} === 5'b0, "R9 immediate", {bsy, cd, io, msg, hs_req}, 0);
    @(negedge clk); bus_rst = 0;
    repeat (2) @(negedge clk);
    chk({bsy, cd, io, msg, hs_req} === 5'b0 && bcnt == 0, "R9 idle", {bsy, cd, io, msg, hs_req}, 0);
    run_vec(VECS[0]);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule